// File: doc/BRIEF.md
# Variable-Page Translation Lookup with Zone Protection

This block is a fully associative translation buffer for a 32-bit virtual address space. Each entry maps one page, and every entry sets its own page size, from 1 KB to 16 MB in steps of four. A lookup supplies a virtual address, an access kind (read, write or fetch) and whether the requester runs in user or privileged mode. All entries are compared in parallel. One clock later the block reports a hit, a miss or a protection fault. A hit also returns the entry index, the page-size code, the masked real page number and the full physical address.

Each entry also names a protection zone. A 32-bit zone register holds a 2-bit code for each of the sixteen zones. That code can hide the entry from user mode, keep the entry's own write and execute permissions, or grant full permission. An entry with a translation ID of zero belongs to every process. Any other ID must match the current process ID. Entries are loaded through a plain indexed write port, one whole entry per clock.

Top module: `vtlb_lookup`

## Requirements
- R1: While `rst_ni` is low, every output is zero and every entry becomes invalid. After reset, any lookup misses until an entry is written.
- R2: A lookup strobed by `lk_valid_i` at a clock edge produces `res_valid_o` high for exactly that next cycle. While `res_valid_o` is high, exactly one of `res_hit_o`, `res_miss_o` and `res_fault_o` is high. While it is low, all three are low.
- R3: An entry takes part only when its valid bit is set. The page covers 1 KB × 4^code bytes, where the size code is 0..7. The entry's page number matches when `lk_vaddr_i[31:10+2*code]` equals the same bits of `{wr_vpn_i,10'b0}`. Page-number bits below the page size are ignored.
- R4: An entry whose translation ID is zero matches any `pid_i`. Any other ID must equal `pid_i`.
- R5: The zone code for zone z is `zone_reg_i[31-2z:30-2z]`, so zone 0 is the top pair. The code is forced to 1 in two cases: the entry's zone number is greater than `NUM_ZONES`, or `ZONE_EN` is 0.
- R6: The zone code decides permissions as follows:
  - Code 0 hides the entry from user lookups, and the search goes on to later entries. Privileged lookups use the entry's own bits.
  - Code 1 uses the entry's own write and execute bits.
  - Code 2 grants write and execute to privileged lookups only.
  - Code 3 grants write and execute to every lookup.
- R7: Among the entries that qualify on valid bit, address, ID and zone visibility, the lowest index is selected. Its permission result is final: a fault on it never falls through to a later entry.
- R8: `lk_type_i` encodes the access kind: 0 is read, 1 is write, 2 is fetch, and 3 behaves as read. A write without write permission is a fault. A fetch without execute permission is a fault. A read never faults.
- R9: On a hit, the outputs are:
  - `res_idx_o` is the entry index.
  - `res_size_o` is the entry's size code.
  - `res_rpn_o` is `{rpn,10'b0} & PA_MASK`.
  - `res_paddr_o` takes the bits of `res_rpn_o` above the page size and the bits of `lk_vaddr_i` below it.
- R10: On a miss or a fault, `res_idx_o`, `res_size_o`, `res_rpn_o` and `res_paddr_o` are zero.
- R11: A write with `wr_en_i` high replaces the whole entry at `wr_idx_i` on the clock edge. Lookups strobed from the next cycle onward see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_valid_i | input | 1 | Valid bit for the new entry |
| wr_vpn_i | input | 22 | Virtual page number, address bits 31:10 |
| wr_size_i | input | 3 | Page-size code |
| wr_tid_i | input | 8 | Translation ID, 0 = any process |
| wr_rpn_i | input | 22 | Real page number, address bits 31:10 |
| wr_w_i | input | 1 | Write permission |
| wr_x_i | input | 1 | Execute permission |
| wr_zone_i | input | 4 | Zone number |
| pid_i | input | 8 | Current process ID |
| zone_reg_i | input | 32 | Zone code register |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_type_i | input | 2 | Access kind |
| lk_user_i | input | 1 | 1 = user mode |
| res_valid_o | output | 1 | Result present |
| res_hit_o | output | 1 | Translation succeeded |
| res_miss_o | output | 1 | No entry qualified |
| res_fault_o | output | 1 | Selected entry denies the access |
| res_idx_o | output | IDX_W | Selected entry index |
| res_size_o | output | 3 | Selected page-size code |
| res_rpn_o | output | 32 | Masked real page base |
| res_paddr_o | output | 32 | Physical address |

## Verification
An error in the stored entries, the zone decode or the priority pick shows up in the result of the very next lookup that touches the affected address. It appears one cycle after the strobe, as a different outcome, index or physical address. For this reason each lookup is followed by an idle cycle in which the outputs are checked again. Entries are laid out so that several of them overlap on purpose, which lets a wrong priority or a lost zone-0 skip change the reported index rather than hide behind an identical translation. Page sizes at both ends of the range and the address just past a page's end expose errors in the mask width.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VPN_W  = 22;
  localparam int OFF_LO = 10;
  localparam int TID_W  = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [2:0]       size;
    logic [TID_W-1:0] tid;
    logic             w;
    logic             x;
    logic [3:0]       zone;
  } key_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [VPN_W-1:0] pn_mask(input logic [2:0] code);
    logic [VPN_W-1:0] one;
    one = VPN_W'(1);
    return ~((one << (2 * code)) - one);
  endfunction
endpackage

// File: rtl/vtlb_entry_store.sv
module vtlb_entry_store
  import vtlb_pkg::*;
#(
  parameter int N_ENT = 64,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  key_t                        wr_key_i,
  input  logic [VPN_W-1:0]            wr_rpn_i,
  output key_t [N_ENT-1:0]            key_o,
  output logic [N_ENT-1:0][VPN_W-1:0] rpn_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_o[g] <= '0;
        rpn_o[g] <= '0;
      end else if (hit_wr) begin
        key_o[g] <= wr_key_i;
        rpn_o[g] <= wr_rpn_i;
      end
    end
  end
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int N_ENT     = 64,
  parameter int NUM_ZONES = 12,
  parameter bit ZONE_EN   = 1'b1
) (
  input  key_t [N_ENT-1:0]  key_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [TID_W-1:0]  pid_i,
  input  logic [31:0]       zone_reg_i,
  input  logic              user_i,
  output logic [N_ENT-1:0]  qual_o,
  output logic [N_ENT-1:0]  w_ok_o,
  output logic [N_ENT-1:0]  x_ok_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic [1:0] zcode;
    logic       addr_eq, tid_ok, hide, full;

    if (ZONE_EN) begin : g_zone
      logic [4:0] sh;
      assign sh    = 5'd30 - {key_i[g].zone, 1'b0};
      assign zcode = (int'(key_i[g].zone) > NUM_ZONES) ? 2'd1
                                                       : 2'(zone_reg_i >> sh);
    end else begin : g_nozone
      logic unused_z;
      assign unused_z = ^{key_i[g].zone, zone_reg_i};
      assign zcode    = 2'd1;
    end

    always_comb begin
      addr_eq = ((vpn_i ^ key_i[g].vpn) & pn_mask(key_i[g].size)) == '0;
      tid_ok  = (key_i[g].tid == '0) || (key_i[g].tid == pid_i);
      hide    = (zcode == 2'd0) && user_i;
      full    = (zcode == 2'd3) || ((zcode == 2'd2) && !user_i);
      qual_o[g] = key_i[g].valid && addr_eq && tid_ok && !hide;
      w_ok_o[g] = key_i[g].w || full;
      x_ok_o[g] = key_i[g].x || full;
    end
  end
endmodule

// File: rtl/vtlb_prio_enc.sv
module vtlb_prio_enc #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan downward so the lowest requesting index is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
  import vtlb_pkg::*;
#(
  parameter int          N_ENT     = 64,
  parameter int          NUM_ZONES = 12,
  parameter bit          ZONE_EN   = 1'b1,
  parameter logic [31:0] PA_MASK   = 32'h3FFF_FFFF,
  parameter int          IDX_W     = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [21:0]      wr_vpn_i,
  input  logic [2:0]       wr_size_i,
  input  logic [7:0]       wr_tid_i,
  input  logic [21:0]      wr_rpn_i,
  input  logic             wr_w_i,
  input  logic             wr_x_i,
  input  logic [3:0]       wr_zone_i,
  input  logic [7:0]       pid_i,
  input  logic [31:0]      zone_reg_i,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_vaddr_i,
  input  logic [1:0]       lk_type_i,
  input  logic             lk_user_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic             res_miss_o,
  output logic             res_fault_o,
  output logic [IDX_W-1:0] res_idx_o,
  output logic [2:0]       res_size_o,
  output logic [31:0]      res_rpn_o,
  output logic [31:0]      res_paddr_o
);
  key_t                        wr_key;
  key_t [N_ENT-1:0]            keys;
  logic [N_ENT-1:0][VPN_W-1:0] rpns;
  logic [N_ENT-1:0]            qual, w_ok, x_ok;
  logic                        any;
  logic [IDX_W-1:0]            sel;

  assign wr_key = '{valid: wr_valid_i, vpn: wr_vpn_i, size: wr_size_i,
                    tid: wr_tid_i, w: wr_w_i, x: wr_x_i, zone: wr_zone_i};

  vtlb_entry_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_key_i (wr_key),
    .wr_rpn_i (wr_rpn_i),
    .key_o    (keys),
    .rpn_o    (rpns)
  );

  vtlb_match #(.N_ENT(N_ENT), .NUM_ZONES(NUM_ZONES), .ZONE_EN(ZONE_EN)) u_match (
    .key_i      (keys),
    .vpn_i      (lk_vaddr_i[31:OFF_LO]),
    .pid_i      (pid_i),
    .zone_reg_i (zone_reg_i),
    .user_i     (lk_user_i),
    .qual_o     (qual),
    .w_ok_o     (w_ok),
    .x_ok_o     (x_ok)
  );

  vtlb_prio_enc #(.N(N_ENT), .IDX_W(IDX_W)) u_prio (
    .req_i (qual),
    .any_o (any),
    .idx_o (sel)
  );

  logic [2:0]  sel_size;
  logic [31:0] sel_rpn, page_m, paddr;
  logic        deny, hit_d, miss_d, fault_d;

  always_comb begin
    sel_size = keys[sel].size;
    sel_rpn  = {rpns[sel], 10'b0} & PA_MASK;
    page_m   = {pn_mask(sel_size), 10'b0};
    paddr    = (sel_rpn & page_m) | (lk_vaddr_i & ~page_m);
    deny     = ((acc_e'(lk_type_i) == ACC_WRITE) && !w_ok[sel]) ||
               ((acc_e'(lk_type_i) == ACC_FETCH) && !x_ok[sel]);
    hit_d    = lk_valid_i && any && !deny;
    fault_d  = lk_valid_i && any && deny;
    miss_d   = lk_valid_i && !any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_miss_o  <= 1'b0;
      res_fault_o <= 1'b0;
      res_idx_o   <= '0;
      res_size_o  <= '0;
      res_rpn_o   <= '0;
      res_paddr_o <= '0;
    end else begin
      res_valid_o <= lk_valid_i;
      res_hit_o   <= hit_d;
      res_miss_o  <= miss_d;
      res_fault_o <= fault_d;
      res_idx_o   <= hit_d ? sel      : '0;
      res_size_o  <= hit_d ? sel_size : '0;
      res_rpn_o   <= hit_d ? sel_rpn  : '0;
      res_paddr_o <= hit_d ? paddr    : '0;
    end
  end
endmodule

// File: rtl/vtlb_lookup_chk.sv
module vtlb_lookup_chk #(
  parameter int          IDX_W   = 6,
  parameter logic [31:0] PA_MASK = 32'h3FFF_FFFF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_valid_i,
  input logic [31:0]      lk_vaddr_i,
  input logic [1:0]       lk_type_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic             res_miss_o,
  input logic             res_fault_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic [2:0]       res_size_o,
  input logic [31:0]      res_rpn_o,
  input logic [31:0]      res_paddr_o
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> res_valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !res_valid_o); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $countones({res_hit_o, res_miss_o, res_fault_o}) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !(res_hit_o || res_miss_o || res_fault_o)); // R2
  AST_READ_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && (lk_type_i == 2'd0)) |=> !res_fault_o); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (!res_hit_o || (res_paddr_o[9:0] == $past(lk_vaddr_i[9:0])))); // R9
  AST_RPN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_o |-> ((res_rpn_o & ~PA_MASK) == '0)); // R9
  AST_NONHIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> (res_idx_o == '0 && res_size_o == '0 &&
                    res_rpn_o == '0 && res_paddr_o == '0)); // R10
endmodule

bind vtlb_lookup vtlb_lookup_chk #(.IDX_W(IDX_W), .PA_MASK(PA_MASK)) u_chk (.*);

// File: tb/vtlb_lookup_tb.sv
module vtlb_lookup_tb;
  localparam int          N_ENT     = 64;
  localparam int          IDX_W     = 6;
  localparam int          NUM_ZONES = 12;
  localparam logic [31:0] PA_MASK   = 32'h3FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             wr_en = 0, wr_valid = 0, wr_w = 0, wr_x = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [21:0]      wr_vpn = '0, wr_rpn = '0;
  logic [2:0]       wr_size = '0;
  logic [7:0]       wr_tid = '0, pid = '0;
  logic [3:0]       wr_zone = '0;
  logic [31:0]      zone_reg = 32'h5555_5555;
  logic             lk_valid = 0, lk_user = 0;
  logic [31:0]      lk_vaddr = '0;
  logic [1:0]       lk_type = '0;
  logic             res_valid, res_hit, res_miss, res_fault;
  logic [IDX_W-1:0] res_idx;
  logic [2:0]       res_size;
  logic [31:0]      res_rpn, res_paddr;

  vtlb_lookup u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_vpn_i(wr_vpn),
    .wr_size_i(wr_size), .wr_tid_i(wr_tid), .wr_rpn_i(wr_rpn), .wr_w_i(wr_w),
    .wr_x_i(wr_x), .wr_zone_i(wr_zone), .pid_i(pid), .zone_reg_i(zone_reg),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_type_i(lk_type), .lk_user_i(lk_user),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_miss_o(res_miss),
    .res_fault_o(res_fault), .res_idx_o(res_idx), .res_size_o(res_size),
    .res_rpn_o(res_rpn), .res_paddr_o(res_paddr)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural entry image
  bit        m_valid [N_ENT];
  int        m_vpn   [N_ENT];
  int        m_size  [N_ENT];
  int        m_tid   [N_ENT];
  int        m_rpn   [N_ENT];
  bit        m_w     [N_ENT];
  bit        m_x     [N_ENT];
  int        m_zone  [N_ENT];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input int idx, input bit v, input logic [31:0] va, input int sz,
                     input int tid, input logic [31:0] pa, input bit w, input bit x,
                     input int zone);
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_valid = v; wr_vpn = va[31:10]; wr_size = 3'(sz);
    wr_tid = 8'(tid); wr_rpn = pa[31:10]; wr_w = w; wr_x = x; wr_zone = 4'(zone);
    m_valid[idx] = v; m_vpn[idx] = int'(va[31:10]); m_size[idx] = sz; m_tid[idx] = tid;
    m_rpn[idx] = int'(pa[31:10]); m_w[idx] = w; m_x[idx] = x; m_zone[idx] = zone;
    @(negedge clk);
    wr_en = 0;
  endtask

  // outcome: 0 miss, 1 hit, 2 fault
  task automatic model(input logic [31:0] va, input int typ, input bit usr,
                       output int oc, output int idx, output int sz,
                       output logic [31:0] rpn, output logic [31:0] pa);
    oc = 0; idx = 0; sz = 0; rpn = 0; pa = 0;
    for (int i = 0; i < N_ENT; i++) begin
      int sh, zc;
      bit w, x;
      logic [31:0] base, lowm;
      if (!m_valid[i]) continue;
      sh = 10 + 2 * m_size[i];
      base = 32'(m_vpn[i]) << 10;
      if ((va >> sh) != (base >> sh)) continue;
      if (m_tid[i] != 0 && m_tid[i] != int'(pid)) continue;
      if (m_zone[i] > NUM_ZONES) zc = 1;
      else zc = int'((zone_reg >> (30 - 2 * m_zone[i])) & 32'd3);
      if (zc == 0 && usr) continue;
      w = m_w[i] || zc == 3 || (zc == 2 && !usr);
      x = m_x[i] || zc == 3 || (zc == 2 && !usr);
      if ((typ == 1 && !w) || (typ == 2 && !x)) begin
        oc = 2;
        return;
      end
      oc = 1; idx = i; sz = m_size[i];
      rpn = (32'(m_rpn[i]) << 10) & PA_MASK;
      lowm = (32'd1 << sh) - 1;
      pa = (rpn & ~lowm) | (va & lowm);
      return;
    end
  endtask

  task automatic look(input logic [31:0] va, input int typ, input bit usr, input string req);
    int oc, idx, sz;
    logic [31:0] rpn, pa;
    model(va, typ, usr, oc, idx, sz, rpn, pa);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_type = 2'(typ); lk_user = usr;
    @(negedge clk);
    lk_valid = 0;
    chk(res_valid == 1, "R2", "valid", 32'(res_valid), 1);
    chk(res_hit == (oc == 1), req, "hit", 32'(res_hit), 32'(oc == 1));
    chk(res_miss == (oc == 0), req, "miss", 32'(res_miss), 32'(oc == 0));
    chk(res_fault == (oc == 2), req, "fault", 32'(res_fault), 32'(oc == 2));
    chk(res_idx == IDX_W'(idx), oc == 1 ? "R7" : "R10", "idx", 32'(res_idx), 32'(idx));
    chk(res_size == 3'(sz), oc == 1 ? "R9" : "R10", "size", 32'(res_size), 32'(sz));
    chk(res_rpn == rpn, oc == 1 ? "R9" : "R10", "rpn", res_rpn, rpn);
    chk(res_paddr == pa, oc == 1 ? "R9" : "R10", "paddr", res_paddr, pa);
    @(negedge clk);
    chk(!res_valid && !res_hit && !res_miss && !res_fault, "R2", "idle", 
        32'({res_valid, res_hit, res_miss, res_fault}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    chk(!res_valid && !res_hit && !res_miss && !res_fault && res_paddr == 0 && res_rpn == 0,
        "R1", "reset outputs", res_paddr, 0);
    rst_n = 1;
    look(32'h1234_5678, 0, 0, "R1");

    // 4K page, write allowed, no execute (R11 write then lookup)
    put(5, 1, 32'h0001_0000, 1, 0, 32'hC123_4000, 1, 0, 1);
    look(32'h0001_0ABC, 0, 0, "R11");
    look(32'h0001_0ABC, 1, 1, "R8");
    look(32'h0001_0ABC, 2, 1, "R8");
    look(32'h0001_0ABC, 3, 1, "R8");
    look(32'h0001_1000, 0, 0, "R3");
    // 16M page with junk below the page size in the stored page number
    put(6, 1, 32'h0305_5400, 7, 0, 32'hF500_0000, 0, 1, 1);
    look(32'h03AB_CDEF, 2, 1, "R3");
    look(32'h03AB_CDEF, 1, 1, "R8");
    look(32'h0400_0000, 0, 0, "R3");
    // 1K page, both edges
    put(7, 1, 32'h0000_8000, 0, 0, 32'h0000_9000, 1, 1, 1);
    look(32'h0000_83FF, 1, 0, "R9");
    look(32'h0000_8400, 0, 0, "R3");
    // invalid entry never matches
    put(2, 0, 32'h0007_0000, 1, 0, 32'h0000_1000, 1, 1, 1);
    look(32'h0007_0010, 0, 0, "R3");
    // translation ID
    put(9, 1, 32'h0020_0000, 1, 5, 32'h0030_0000, 1, 1, 1);
    pid = 8'd5;
    look(32'h0020_0044, 0, 1, "R4");
    pid = 8'd6;
    look(32'h0020_0044, 0, 1, "R4");
    look(32'h0001_0004, 0, 1, "R4");
    // overlapping entries: lowest index, no fall-through on fault
    put(40, 1, 32'h0040_0000, 2, 0, 32'h0100_0000, 1, 1, 1);
    put(12, 1, 32'h0040_0000, 1, 0, 32'h0200_0000, 0, 1, 1);
    look(32'h0040_0010, 0, 0, "R7");
    look(32'h0040_2010, 0, 0, "R7");
    look(32'h0040_0010, 1, 0, "R7");
    // zone codes on zone 2 (bits 27:26)
    put(20, 1, 32'h0080_0000, 1, 0, 32'h0A00_0000, 0, 0, 2);
    put(21, 1, 32'h0080_0000, 1, 0, 32'h0B00_0000, 1, 1, 1);
    zone_reg = 32'h5155_5555;
    look(32'h0080_0123, 0, 1, "R6");
    look(32'h0080_0123, 0, 0, "R6");
    look(32'h0080_0123, 1, 0, "R6");
    zone_reg = 32'h5955_5555;
    look(32'h0080_0123, 1, 1, "R6");
    look(32'h0080_0123, 1, 0, "R6");
    zone_reg = 32'h5D55_5555;
    look(32'h0080_0123, 2, 1, "R6");
    // zone 12 in range (bits 7:6), zone 14 out of range (bits 3:2)
    put(30, 1, 32'h00C0_0000, 1, 0, 32'h0C00_0000, 0, 0, 14);
    put(31, 1, 32'h00D0_0000, 1, 0, 32'h0D00_0000, 0, 0, 12);
    zone_reg = 32'h5555_55DD;
    look(32'h00C0_0008, 1, 1, "R5");
    look(32'h00D0_0008, 1, 1, "R5");
    // overwrite removes the old mapping
    put(5, 0, 32'h0001_0000, 1, 0, 32'h0, 0, 0, 1);
    look(32'h0001_0ABC, 0, 0, "R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule